// File: doc/BRIEF.md
# ATA PIO Register and Data Access Sequencer

This block carries out one ATA-style programmed-I/O access at a time on a 16-bit parallel device bus. The host hands over a request through a valid/ready handshake. Each request holds a 5-bit device address, a direction flag, a flag that chooses the timing set, and the write data for writes. The sequencer drives the address first. After a programmable setup time it pulses the read or write strobe. A write drives the data bus for the whole strobe and for a programmable hold time after it. A read captures the device data on the edge that ends the strobe. A programmable recovery time then runs before the next request is accepted.

There are two timing sets, one for register accesses and one for PIO data-port accesses. Each set has four cycle counts: setup, strobe, write hold and recovery. The device ready line can lengthen the strobe. That lengthening is capped by a programmable wait limit, and when the cap is reached the access ends with an error flag. The result comes back as a one-cycle done pulse, with the read data and the error flag valid in the same cycle.

Top module: `pio_seq`

## Requirements
- R1: `req_ready` is 1 after reset and whenever no access is in progress. It is 0 from the cycle after a request is accepted until the recovery phase has finished. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: `dev_addr` takes `req_addr` in the cycle after acceptance and holds that value until the next acceptance. Bits [2:0] are the three address lines and bits [4:3] are the two chip selects. The strobe asserts after exactly T1 cycles of setup.
- R3: A read drives `dev_rd_n` low and a write drives `dev_wr_n` low, and the two are never low together. While `dev_iordy` is 1, the strobe lasts exactly T2 cycles.
- R4: `dev_iordy` is sampled at the end of each strobe cycle, starting with the T2-th. While it is sampled 0, the strobe is extended one cycle at a time, for at most `wait_limit` extra cycles.
- R5: If `dev_iordy` is still 0 when `wait_limit` extra cycles have already been added, the strobe ends and `rsp_err` is 1 together with `rsp_done`. Otherwise `rsp_err` is 0 with `rsp_done`.
- R6: On writes, `dev_data_oe` is 1 and `dev_data_out` equals the request data for every strobe cycle and for T4 cycles after the strobe. On reads, `dev_data_oe` stays 0.
- R7: On reads, `rsp_rdata` equals `dev_data_in` as sampled on the clock edge that deasserts the strobe.
- R8: `rsp_done` is a one-cycle pulse in the first cycle after the strobe deasserts.
- R9: After the strobe, `req_ready` stays 0 for the recovery time. For reads this is TEOC cycles. For writes it is the larger of TEOC and T4.
- R10: When `req_is_data` is 1 the access uses the `dat_*` timing set. When it is 0 the access uses the `reg_*` timing set.
- R11: A timing value programmed as 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 1 = PIO data timing set, 0 = register timing set |
| req_addr | input | 5 | Address lines [2:0], chip selects [4:3] |
| req_wdata | input | 16 | Write data |
| reg_t1 | input | 8 | Register set: address setup cycles |
| reg_t2 | input | 8 | Register set: strobe cycles |
| reg_t4 | input | 8 | Register set: write hold cycles |
| reg_teoc | input | 8 | Register set: recovery cycles |
| dat_t1 | input | 8 | Data set: address setup cycles |
| dat_t2 | input | 8 | Data set: strobe cycles |
| dat_t4 | input | 8 | Data set: write hold cycles |
| dat_teoc | input | 8 | Data set: recovery cycles |
| wait_limit | input | 8 | Maximum ready-wait extension cycles |
| rsp_done | output | 1 | Access finished (one-cycle pulse) |
| rsp_err | output | 1 | Wait limit expired, valid with rsp_done |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| dev_addr | output | 5 | Device address and chip selects |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_data_out | output | 16 | Data driven to the device |
| dev_data_oe | output | 1 | Data output enable |
| dev_data_in | input | 16 | Data from the device |
| dev_iordy | input | 1 | Device ready, low requests wait |

## Verification
The assertions assume that `wait_limit` does not change while an access is in progress, because the strobe-length bound is taken from its current value. They also assume that the timing inputs stay steady from acceptance to the end of the strobe. The stimulus reprograms both timing sets and the wait limit only while the sequencer is idle, between accesses. It raises `req_valid` only when `req_ready` is observed high. The device model changes `dev_iordy` and `dev_data_in` only on falling clock edges.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_t;

  // positions of the four phase values inside a timing set
  localparam int unsigned IX_SETUP = 0;
  localparam int unsigned IX_STRB  = 1;
  localparam int unsigned IX_HOLD  = 2;
  localparam int unsigned IX_RECOV = 3;
  localparam int unsigned N_PHASE  = 4;

  // a programmed zero behaves as one cycle
  function automatic logic [31:0] floor_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  function automatic logic [31:0] larger(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

  // recovery length: writes must also cover the data hold
  function automatic logic [31:0] recov_len(input logic wr, input logic [31:0] teoc,
                                            input logic [31:0] hold);
    return wr ? larger(teoc, hold) : teoc;
  endfunction

endpackage

// File: rtl/pio_tmg_sel.sv
module pio_tmg_sel
  import pio_seq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic                        use_data,
  input  logic [N_PHASE-1:0][TW-1:0]  reg_set,
  input  logic [N_PHASE-1:0][TW-1:0]  dat_set,
  output logic [N_PHASE-1:0][TW-1:0]  eff_set
);

  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    logic [TW-1:0] raw;
    assign raw        = use_data ? dat_set[g] : reg_set[g];
    assign eff_set[g] = TW'(floor_one(32'(raw)));
  end

endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] cnt,
  output logic         zero
);

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (dec_en && !zero) cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_seq_pkg::*;
(
  input  seq_state_t state,
  input  logic       req_valid,
  input  logic       phase_zero,
  input  logic       iordy,
  input  logic       wait_hit,
  output seq_state_t nxt_state,
  output logic       accept,
  output logic       strb_begin,
  output logic       strb_end,
  output logic       strb_timeout,
  output logic       wait_step,
  output logic       recov_end
);

  always_comb begin
    nxt_state    = state;
    accept       = 1'b0;
    strb_begin   = 1'b0;
    strb_end     = 1'b0;
    strb_timeout = 1'b0;
    wait_step    = 1'b0;
    recov_end    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept    = 1'b1;
          nxt_state = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (phase_zero) begin
          strb_begin = 1'b1;
          nxt_state  = ST_STRB;
        end
      end
      ST_STRB: begin
        if (phase_zero) begin
          if (iordy) begin
            strb_end  = 1'b1;
            nxt_state = ST_RECOV;
          end else if (wait_hit) begin
            strb_end     = 1'b1;
            strb_timeout = 1'b1;
            nxt_state    = ST_RECOV;
          end else begin
            wait_step = 1'b1;
          end
        end
      end
      ST_RECOV: begin
        if (phase_zero) begin
          recov_end = 1'b1;
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int TW = 8,
  parameter int WW = 8,
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_is_data,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] reg_t1,
  input  logic [TW-1:0] reg_t2,
  input  logic [TW-1:0] reg_t4,
  input  logic [TW-1:0] reg_teoc,
  input  logic [TW-1:0] dat_t1,
  input  logic [TW-1:0] dat_t2,
  input  logic [TW-1:0] dat_t4,
  input  logic [TW-1:0] dat_teoc,
  input  logic [WW-1:0] wait_limit,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [DW-1:0] dev_data_out,
  output logic          dev_data_oe,
  input  logic [DW-1:0] dev_data_in,
  input  logic          dev_iordy
);

  // ---------------- timing set selection ----------------
  logic [N_PHASE-1:0][TW-1:0] reg_set, dat_set, sel_set;
  assign reg_set[IX_SETUP] = reg_t1;
  assign reg_set[IX_STRB]  = reg_t2;
  assign reg_set[IX_HOLD]  = reg_t4;
  assign reg_set[IX_RECOV] = reg_teoc;
  assign dat_set[IX_SETUP] = dat_t1;
  assign dat_set[IX_STRB]  = dat_t2;
  assign dat_set[IX_HOLD]  = dat_t4;
  assign dat_set[IX_RECOV] = dat_teoc;

  pio_tmg_sel #(.TW(TW)) u_sel (
    .use_data (req_is_data),
    .reg_set  (reg_set),
    .dat_set  (dat_set),
    .eff_set  (sel_set)
  );

  // ---------------- state and latched request ----------------
  seq_state_t    state, nxt_state;
  logic          cur_write;
  logic [TW-1:0] cur_t2, cur_t4, cur_teoc;
  logic [DW-1:0] cur_wdata;

  // named internal events
  logic accept_w, strb_begin_w, strb_end_w, strb_timeout_w, wait_step_w, recov_end_w;
  logic phase_zero_w, wait_hit_w;

  pio_seq_fsm u_fsm (
    .state        (state),
    .req_valid    (req_valid),
    .phase_zero   (phase_zero_w),
    .iordy        (dev_iordy),
    .wait_hit     (wait_hit_w),
    .nxt_state    (nxt_state),
    .accept       (accept_w),
    .strb_begin   (strb_begin_w),
    .strb_end     (strb_end_w),
    .strb_timeout (strb_timeout_w),
    .wait_step    (wait_step_w),
    .recov_end    (recov_end_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_write <= 1'b0;
      cur_t2    <= '0;
      cur_t4    <= '0;
      cur_teoc  <= '0;
      cur_wdata <= '0;
      dev_addr  <= '0;
    end else begin
      state <= nxt_state;
      if (accept_w) begin
        cur_write <= req_write;
        cur_t2    <= sel_set[IX_STRB];
        cur_t4    <= sel_set[IX_HOLD];
        cur_teoc  <= sel_set[IX_RECOV];
        cur_wdata <= req_wdata;
        dev_addr  <= req_addr;
      end
    end
  end

  // ---------------- phase counter ----------------
  logic [TW-1:0] recov_cycles_w;
  logic [TW-1:0] phase_load_val;
  logic          phase_load;
  logic [TW-1:0] phase_cnt;

  assign recov_cycles_w = TW'(recov_len(cur_write, 32'(cur_teoc), 32'(cur_t4)));

  always_comb begin
    phase_load     = 1'b0;
    phase_load_val = '0;
    if (accept_w) begin
      phase_load     = 1'b1;
      phase_load_val = sel_set[IX_SETUP] - 1'b1;
    end else if (strb_begin_w) begin
      phase_load     = 1'b1;
      phase_load_val = cur_t2 - 1'b1;
    end else if (strb_end_w) begin
      phase_load     = 1'b1;
      phase_load_val = recov_cycles_w - 1'b1;
    end
  end

  pio_phase_ctr #(.W(TW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_load_val),
    .dec_en   (state != ST_IDLE),
    .cnt      (phase_cnt),
    .zero     (phase_zero_w)
  );

  // ---------------- ready-wait extension counter ----------------
  logic [WW-1:0] wait_cnt;
  assign wait_hit_w = (wait_cnt == wait_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wait_cnt <= '0;
    else if (accept_w)    wait_cnt <= '0;
    else if (wait_step_w) wait_cnt <= wait_cnt + 1'b1;
  end

  // ---------------- write data hold counter ----------------
  logic [TW-1:0] hold_cnt;
  logic          hold_zero_w;

  pio_phase_ctr #(.W(TW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (strb_end_w),
    .load_val (cur_write ? cur_t4 : '0),
    .dec_en   (state == ST_RECOV),
    .cnt      (hold_cnt),
    .zero     (hold_zero_w)
  );

  // ---------------- device side outputs ----------------
  logic strobe_on_w;
  assign strobe_on_w  = (state == ST_STRB);
  assign dev_rd_n     = !(strobe_on_w && !cur_write);
  assign dev_wr_n     = !(strobe_on_w && cur_write);
  assign dev_data_out = cur_wdata;
  assign dev_data_oe  = cur_write && (strobe_on_w || !hold_zero_w);
  assign req_ready    = (state == ST_IDLE);

  // ---------------- response ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= strb_end_w;
      rsp_err  <= strb_timeout_w;
      if (strb_end_w && !cur_write) rsp_rdata <= dev_data_in;
    end
  end

endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int TW = 8,
  parameter int WW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          accept_w,
  input logic [AW-1:0] dev_addr,
  input logic          dev_rd_n,
  input logic          dev_wr_n,
  input logic          dev_data_oe,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [TW-1:0] cur_t2,
  input logic [WW-1:0] wait_limit
);

  localparam int LW = TW + WW + 1;

  logic          strobe_low;
  logic [LW-1:0] strobe_len;
  logic [LW-1:0] strobe_cap;

  assign strobe_low = !dev_rd_n || !dev_wr_n;
  assign strobe_cap = LW'(cur_t2) + LW'(wait_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          strobe_len <= '0;
    else if (strobe_low) strobe_len <= strobe_len + 1'b1;
    else                 strobe_len <= '0;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> !req_ready);

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(dev_addr));

  // R4
  strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> (strobe_len < strobe_cap));

  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_data_oe |-> dev_rd_n);

  // R8
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(dev_rd_n && dev_wr_n));

endmodule

bind pio_seq pio_seq_chk #(.TW(TW), .WW(WW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .accept_w    (accept_w),
  .dev_addr    (dev_addr),
  .dev_rd_n    (dev_rd_n),
  .dev_wr_n    (dev_wr_n),
  .dev_data_oe (dev_data_oe),
  .rsp_done    (rsp_done),
  .rsp_err     (rsp_err),
  .cur_t2      (cur_t2),
  .wait_limit  (wait_limit)
);

// File: tb/tb_pio_seq.sv
module tb_pio_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_is_data = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  reg_t1 = 8'd1, reg_t2 = 8'd1, reg_t4 = 8'd1, reg_teoc = 8'd1;
  logic [7:0]  dat_t1 = 8'd1, dat_t2 = 8'd1, dat_t4 = 8'd1, dat_teoc = 8'd1;
  logic [7:0]  wait_limit = '0;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [4:0]  dev_addr;
  logic        dev_rd_n, dev_wr_n, dev_data_oe;
  logic [15:0] dev_data_out;
  logic [15:0] dev_data_in = '0;
  logic        dev_iordy = 1'b1;

  always #5 clk = ~clk;

  pio_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_is_data(req_is_data), .req_addr(req_addr), .req_wdata(req_wdata),
    .reg_t1(reg_t1), .reg_t2(reg_t2), .reg_t4(reg_t4), .reg_teoc(reg_teoc),
    .dat_t1(dat_t1), .dat_t2(dat_t2), .dat_t4(dat_t4), .dat_teoc(dat_teoc),
    .wait_limit(wait_limit),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_data_out(dev_data_out), .dev_data_oe(dev_data_oe),
    .dev_data_in(dev_data_in), .dev_iordy(dev_iordy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // vector: wr, is_data, addr[5], wdata[16], rdval[16], low[4], t1, t2, t4, teoc, limit (4 each)
  localparam int NV = 9;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'h1A, 16'h0000, 16'hA5C3, 4'd0,  4'd1, 4'd2, 4'd1, 4'd3, 4'd4},
    {1'b1, 1'b0, 5'h0B, 16'h1234, 16'h0000, 4'd0,  4'd2, 4'd3, 4'd2, 4'd4, 4'd4},
    {1'b1, 1'b1, 5'h10, 16'hBEEF, 16'h0000, 4'd0,  4'd3, 4'd2, 4'd6, 4'd2, 4'd1},
    {1'b0, 1'b1, 5'h08, 16'h0000, 16'h5A5A, 4'd5,  4'd2, 4'd3, 4'd1, 4'd2, 4'd8},
    {1'b0, 1'b0, 5'h17, 16'h0000, 16'h0F0F, 4'd10, 4'd1, 4'd2, 4'd1, 4'd1, 4'd3},
    {1'b1, 1'b1, 5'h03, 16'hC001, 16'h0000, 4'd0,  4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {1'b0, 1'b1, 5'h11, 16'h0000, 16'h7777, 4'd1,  4'd1, 4'd1, 4'd1, 4'd1, 4'd0},
    {1'b1, 1'b0, 5'h0E, 16'h8421, 16'h0000, 4'd2,  4'd1, 4'd4, 4'd3, 4'd2, 4'd2},
    {1'b0, 1'b1, 5'h1F, 16'h0000, 16'hFACE, 4'd6,  4'd7, 4'd5, 4'd1, 4'd7, 4'd2}
  };

  task automatic run_vec(input logic [62:0] v);
    logic wr, dt;
    logic [4:0] ad;
    logic [15:0] wd, rd;
    int lo, t1, t2, t4, te, lm;
    int e1, e2, e4, ee, base, cap, elen, eerr, erec, ehold;
    int n, i, r, h, g, bad_pol, bad_drv, bad_rdy, done_late;
    wr = v[62]; dt = v[61]; ad = v[60:56]; wd = v[55:40]; rd = v[39:24];
    lo = int'(v[23:20]); t1 = int'(v[19:16]); t2 = int'(v[15:12]);
    t4 = int'(v[11:8]); te = int'(v[7:4]); lm = int'(v[3:0]);
    e1 = fl1(t1); e2 = fl1(t2); e4 = fl1(t4); ee = fl1(te);
    base  = mx(e2, lo + 1);
    cap   = e2 + lm;
    elen  = (base < cap) ? base : cap;
    eerr  = (base > cap) ? 1 : 0;
    erec  = wr ? mx(ee, e4) : ee;
    ehold = wr ? e4 : 0;
    @(negedge clk);
    // the unselected set is programmed to 9 so a wrong selection shows up (R10)
    if (dt) begin
      dat_t1 = 8'(t1); dat_t2 = 8'(t2); dat_t4 = 8'(t4); dat_teoc = 8'(te);
      reg_t1 = 8'd9; reg_t2 = 8'd9; reg_t4 = 8'd9; reg_teoc = 8'd9;
    end else begin
      reg_t1 = 8'(t1); reg_t2 = 8'(t2); reg_t4 = 8'(t4); reg_teoc = 8'(te);
      dat_t1 = 8'd9; dat_t2 = 8'd9; dat_t4 = 8'd9; dat_teoc = 8'd9;
    end
    wait_limit  = 8'(lm);
    req_write   = wr;
    req_is_data = dt;
    req_addr    = ad;
    req_wdata   = wd;
    dev_data_in = ~rd;
    dev_iordy   = 1'b1;
    check("R1 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~ad;
    req_wdata = ~wd;
    n = 0; g = 0;
    while (dev_rd_n && dev_wr_n && g < 500) begin
      n++; g++;
      @(negedge clk);
    end
    check("R2 R10 setup cycles", n, e1);
    check("R2 address driven", int'(dev_addr), int'(ad));
    i = 0; bad_pol = 0; bad_drv = 0; bad_rdy = 0;
    while (!(dev_rd_n && dev_wr_n) && g < 500) begin
      i++; g++;
      if (wr ? (dev_wr_n || !dev_rd_n) : (dev_rd_n || !dev_wr_n)) bad_pol++;
      if (wr && (!dev_data_oe || dev_data_out !== wd)) bad_drv++;
      if (!wr && dev_data_oe) bad_drv++;
      if (req_ready) bad_rdy++;
      dev_data_in = rd;
      dev_iordy   = (i > lo);
      @(negedge clk);
    end
    dev_iordy   = 1'b1;
    dev_data_in = 16'hDEAD;
    check("R3 strobe polarity", bad_pol, 0);
    check("R1 ready low during strobe", bad_rdy, 0);
    check("R6 data drive during strobe", bad_drv, 0);
    if (lo == 0) check("R3 R10 R11 strobe length", i, elen);
    else         check("R4 extended strobe length", i, elen);
    check("R8 done pulse", int'(rsp_done), 1);
    check("R5 error flag", int'(rsp_err), eerr);
    if (!wr) check("R7 read capture", int'(rsp_rdata), int'(rd));
    r = 0; h = 0; done_late = 0;
    while (!req_ready && g < 500) begin
      r++; g++;
      if (dev_data_oe && dev_data_out === wd) h++;
      if (r > 1 && rsp_done) done_late++;
      @(negedge clk);
    end
    check("R9 recovery cycles", r, erec);
    check("R6 write hold cycles", h, ehold);
    check("R8 done single cycle", done_late, 0);
    check("R2 address held through recovery", int'(dev_addr), int'(ad));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", int'(req_ready), 1);
    check("R3 reset read strobe", int'(dev_rd_n), 1);
    check("R3 reset write strobe", int'(dev_wr_n), 1);
    check("R6 reset output enable", int'(dev_data_oe), 0);
    check("R8 reset done", int'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule